// File: doc/BRIEF.md
# Synthesizer Serial Programming Port

This block receives a three-wire serial stream (data, shift clock, load strobe) and turns it into the parallel settings of a fractional-N frequency synthesizer core. Every rising edge of the shift clock moves one data bit into a 24-bit shift register. A rising edge of the load strobe copies the word into one of four internal registers. The two lowest bits of the word choose the register.

All three serial inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and its edges are detected in the system clock domain. The modulus field is written through the reference-divider register and goes to a staging buffer. It reaches the active modulus output only when the divider register is next written. A one-cycle update pulse on every divider write lets downstream logic reload the integer, fraction and modulus together.

Top module: `synp_port`

## Requirements
- R1: The shift register is 24 bits wide and takes one bit per shift-clock rising edge. When more than 24 bits are sent, only the last 24 are kept.
- R2: Bits arrive most significant first: the first of 24 bits sent ends up in bit 23 of the word.
- R3: On a load-strobe rising edge, word bits [1:0] select the destination: 0 is divider, 1 is reference divider, 2 is control, 3 is noise/spur. No other register changes.
- R4: Field positions are as follows. Divider: integer [22:14], fraction [13:2]. Reference divider: reference count [17:14], modulus [13:2]. Control and noise/spur: payload [23:2].
- R5: A reference-divider write places the modulus in a staging buffer and leaves the active modulus output unchanged.
- R6: A divider write copies the staged modulus to the active modulus output in the same cycle that it updates integer and fraction.
- R7: Every divider write raises `upd_o` for exactly one cycle. Writes to other registers never raise it.
- R8: After reset, all register outputs are zero, and both the active and the staged modulus are 2.
- R9: Register outputs change on the third system-clock edge that samples the load strobe high, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| sdata_i | input | 1 | Serial data (asynchronous) |
| le_i | input | 1 | Load strobe (asynchronous) |
| int_o | output | 9 | Integer divide value |
| frac_o | output | 12 | Fraction value |
| mod_o | output | 12 | Active modulus |
| rdiv_o | output | 4 | Reference divide count |
| ctrl_o | output | 22 | Control payload |
| nspur_o | output | 22 | Noise/spur payload |
| upd_o | output | 1 | One-cycle divider-write pulse |

## Verification
A load-strobe rise that is first sampled at edge k passes two synchronizer flops. The edge detector fires after edge k+1, and the registered outputs change at edge k+2. The bench drives the strobe high just after a falling edge and checks that the outputs still hold their old values after two rising edges and show the new values after the third. It samples one time unit after each edge.

Shift-clock half periods last four system clocks, so every bit is captured well inside its data window. Update pulses are counted by a process on every edge, so a pulse that lasts one cycle is never missed.

// File: rtl/synp_pkg.sv
package synp_pkg;
  localparam int WORD_W   = 24;
  localparam int ADDR_W   = 2;
  localparam int INT_W    = 9;
  localparam int FRAC_W   = 12;
  localparam int MOD_W    = 12;
  localparam int RDIV_W   = 4;
  localparam int PAY_W    = WORD_W - ADDR_W;
  localparam int INT_LSB  = ADDR_W + FRAC_W;
  localparam int RDIV_LSB = ADDR_W + MOD_W;
  localparam logic [MOD_W-1:0] MOD_RST = MOD_W'(2);

  typedef enum logic [ADDR_W-1:0] {
    SEL_DIV  = 2'd0,
    SEL_REF  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NS   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/synp_sync.sv
module synp_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= d_i;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/synp_edge.sv
module synp_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev;

  generate
    for (genvar i = 0; i < W; i++) begin : g_chk
      a_r9_rise_single : assert property (@(posedge clk) disable iff (rst)
        rise_o[i] |=> !rise_o[i]);
    end
  endgenerate
endmodule

// File: rtl/synp_shift.sv
module synp_shift
  import synp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  always_ff @(posedge clk) begin
    if (rst)          word_o <= '0;
    else if (shift_i) word_o <= {word_o[WORD_W-2:0], bit_i};
  end

  a_r1_hold_no_shift : assert property (@(posedge clk) disable iff (rst)
    !shift_i |=> $stable(word_o));
endmodule

// File: rtl/synp_bank.sv
module synp_bank
  import synp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [INT_W-1:0]  int_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic [MOD_W-1:0]  mod_o,
  output logic [RDIV_W-1:0] rdiv_o,
  output logic [PAY_W-1:0]  ctrl_o,
  output logic [PAY_W-1:0]  nspur_o,
  output logic              upd_o
);
  reg_sel_e         sel;
  logic [MOD_W-1:0] mod_stage;

  assign sel = reg_sel_e'(word_i[ADDR_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      int_o     <= '0;
      frac_o    <= '0;
      mod_o     <= MOD_RST;
      mod_stage <= MOD_RST;
      rdiv_o    <= '0;
      ctrl_o    <= '0;
      nspur_o   <= '0;
      upd_o     <= 1'b0;
    end else begin
      upd_o <= 1'b0;
      if (load_i) begin
        unique case (sel)
          SEL_DIV: begin
            int_o  <= word_i[INT_LSB +: INT_W];
            frac_o <= word_i[ADDR_W +: FRAC_W];
            mod_o  <= mod_stage;
            upd_o  <= 1'b1;
          end
          SEL_REF: begin
            rdiv_o    <= word_i[RDIV_LSB +: RDIV_W];
            mod_stage <= word_i[ADDR_W +: MOD_W];
          end
          SEL_CTRL: ctrl_o  <= word_i[WORD_W-1:ADDR_W];
          SEL_NS:   nspur_o <= word_i[WORD_W-1:ADDR_W];
          default: ;
        endcase
      end
    end
  end

  a_r5_mod_only_on_update : assert property (@(posedge clk) disable iff (rst)
    !$stable(mod_o) |-> upd_o);
  a_r7_pulse_one_cycle : assert property (@(posedge clk) disable iff (rst)
    upd_o |=> !upd_o);
  a_r3_ctrl_untouched : assert property (@(posedge clk) disable iff (rst)
    (load_i && sel != SEL_CTRL) |=> $stable(ctrl_o));
  a_r3_nspur_untouched : assert property (@(posedge clk) disable iff (rst)
    (load_i && sel != SEL_NS) |=> $stable(nspur_o));
  a_r6_int_with_pulse : assert property (@(posedge clk) disable iff (rst)
    !$stable(int_o) |-> upd_o);
endmodule

// File: rtl/synp_port.sv
module synp_port
  import synp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              le_i,
  output logic [INT_W-1:0]  int_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic [MOD_W-1:0]  mod_o,
  output logic [RDIV_W-1:0] rdiv_o,
  output logic [PAY_W-1:0]  ctrl_o,
  output logic [PAY_W-1:0]  nspur_o,
  output logic              upd_o
);
  logic [2:0]        lvl;
  logic [1:0]        rise;
  logic [WORD_W-1:0] word;

  synp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i({le_i, sclk_i, sdata_i}), .q_o(lvl));

  synp_edge #(.W(2)) u_edge (
    .clk(clk), .rst(rst), .lvl_i(lvl[2:1]), .rise_o(rise));

  synp_shift u_shift (
    .clk(clk), .rst(rst), .shift_i(rise[0]), .bit_i(lvl[0]), .word_o(word));

  synp_bank u_bank (
    .clk(clk), .rst(rst), .load_i(rise[1]), .word_i(word),
    .int_o(int_o), .frac_o(frac_o), .mod_o(mod_o), .rdiv_o(rdiv_o),
    .ctrl_o(ctrl_o), .nspur_o(nspur_o), .upd_o(upd_o));
endmodule

// File: tb/synp_port_bench.sv
module synp_port_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdata = 1'b0, le = 1'b0;
  logic [8:0]  int_v;
  logic [11:0] frac_v, mod_v;
  logic [3:0]  rdiv_v;
  logic [21:0] ctrl_v, ns_v;
  logic        upd;
  int checks = 0, fails = 0, pulses = 0;
  bit done = 0;

  always #2 clk = ~clk;

  synp_port u_synp_port (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sdata_i(sdata), .le_i(le),
    .int_o(int_v), .frac_o(frac_v), .mod_o(mod_v), .rdiv_o(rdiv_v),
    .ctrl_o(ctrl_v), .nspur_o(ns_v), .upd_o(upd));

  always @(posedge clk) if (!rst && upd) pulses <= pulses + 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shift_bits(logic [31:0] w, int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); sdata = w[i];
      repeat (4) @(negedge clk); sclk = 1'b1;
      repeat (4) @(negedge clk); sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic strobe();
    le = 1'b1;
    repeat (4) @(negedge clk); le = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [23:0] dword(logic [8:0] i, logic [11:0] f);
    return {1'b0, i, f, 2'd0};
  endfunction
  function automatic logic [23:0] rword(logic [3:0] r, logic [11:0] m);
    return {6'd0, r, m, 2'd1};
  endfunction

  task automatic t_reset();
    chk("R8 int", int_v, 0);  chk("R8 frac", frac_v, 0);
    chk("R8 mod", mod_v, 2);  chk("R8 rdiv", rdiv_v, 0);
    chk("R8 ctrl", ctrl_v, 0); chk("R8 ns", ns_v, 0);
    chk("R8 upd", upd, 0);
  endtask

  task automatic t_stage_mod();
    int p0 = pulses;
    shift_bits(rword(4'd5, 12'd100), 24); strobe();
    chk("R4 rdiv", rdiv_v, 5);
    chk("R5 mod held", mod_v, 2);
    chk("R7 no pulse on ref", pulses, p0);
  endtask

  task automatic t_div_latency();
    int p0 = pulses;
    shift_bits(dword(9'd200, 12'd37), 24);
    le = 1'b1;
    repeat (2) @(posedge clk); #1;
    chk("R9 not early int", int_v, 0);
    chk("R9 not early mod", mod_v, 2);
    @(posedge clk); #1;
    chk("R9 int on time", int_v, 200);
    chk("R6 mod with int", mod_v, 100);
    chk("R4 frac", frac_v, 37);
    @(negedge clk); repeat (3) @(negedge clk); le = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 one pulse", pulses, p0 + 1);
  endtask

  task automatic t_ctrl_ns();
    int p0 = pulses;
    shift_bits({22'h2AC35B, 2'd2}, 24); strobe();
    chk("R2 ctrl msb first", ctrl_v, 22'h2AC35B);
    chk("R3 ns untouched", ns_v, 0);
    shift_bits({22'h15A0F3, 2'd3}, 24); strobe();
    chk("R3 ns", ns_v, 22'h15A0F3);
    chk("R3 ctrl kept", ctrl_v, 22'h2AC35B);
    chk("R3 int kept", int_v, 200);
    chk("R7 no pulse ctrl/ns", pulses, p0);
  endtask

  task automatic t_mod_max();
    shift_bits(rword(4'd15, 12'd4095), 24); strobe();
    shift_bits({22'h000001, 2'd2}, 24); strobe();
    chk("R5 mod still old", mod_v, 100);
    chk("R4 rdiv max", rdiv_v, 15);
    shift_bits(dword(9'd511, 12'd4094), 24); strobe();
    chk("R6 mod max", mod_v, 4095);
    chk("R4 int max", int_v, 511);
  endtask

  task automatic t_overlong();
    shift_bits(32'h3F, 6);
    shift_bits({8'd0, 22'h0BEEF1, 2'd3}, 24);
    strobe();
    chk("R1 last 24 bits kept", ns_v, 22'h0BEEF1);
  endtask

  initial begin
    repeat (4) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_stage_mod();
    t_div_latency();
    t_ctrl_ns();
    t_mod_max();
    t_overlong();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule